// File: doc/BRIEF.md
# Bidirectional Shift Register with Load

This block is an N-bit storage register that, on each clock edge, either keeps its word, moves every bit one place toward index 0, moves every bit one place toward index N-1, or takes a whole new word from a parallel input. Each shift direction has its own serial input, used to fill the stage that is left empty by the move. The stored word is visible on a registered parallel output. Two serial outputs show the bits at each end, so the block can be chained with neighbours in either direction.

The operation is chosen by one of two control schemes, picked at run time by `pair_ctrl`. With `pair_ctrl` low, a two-bit operation code selects the action. With `pair_ctrl` high, a shift enable and a load enable choose the action, and the shift enable wins over the load enable. A synchronous active-high reset overrides both schemes. Typical uses are serial-to-parallel and parallel-to-serial conversion, and bit-serial datapaths that need to move data in both directions.

Top module: `bidir_shreg`

## Requirements
- R1: While `rst` is high at a rising edge, every stored bit becomes 0 on that edge, whatever the other inputs are.
- R2: With `pair_ctrl`=0 and `op_code`=2'b00, the stored word is unchanged after the edge.
- R3: With `pair_ctrl`=0 and `op_code`=2'b01, stage i takes the old stage i+1, and stage N-1 takes `fill_dn`.
- R4: With `pair_ctrl`=0 and `op_code`=2'b10, stage i takes the old stage i-1, and stage 0 takes `fill_up`.
- R5: With `pair_ctrl`=0 and `op_code`=2'b11, the stored word becomes `word_in` in one edge.
- R6: With `pair_ctrl`=1, `shift_req`=0 and `load_req`=0, the stored word is unchanged.
- R7: With `pair_ctrl`=1, `shift_req`=0 and `load_req`=1, the stored word becomes `word_in`.
- R8: With `pair_ctrl`=1 and `shift_req`=1, the word shifts toward the higher index exactly as in R4, whatever `load_req` is.
- R9: `end_lo` always equals `word_out[0]`, and `end_hi` always equals `word_out[N-1]`.
- R10: The inputs of the control scheme that is not selected have no effect: `op_code` is ignored when `pair_ctrl`=1, and `shift_req`/`load_req` are ignored when `pair_ctrl`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pair_ctrl | input | 1 | 0: use `op_code`; 1: use `shift_req`/`load_req` |
| op_code | input | 2 | 00 hold, 01 shift toward index 0, 10 shift toward index N-1, 11 load |
| shift_req | input | 1 | Shift toward index N-1 (pair scheme; overrides load) |
| load_req | input | 1 | Parallel load (pair scheme) |
| fill_dn | input | 1 | Serial bit entering stage N-1 on a downward shift |
| fill_up | input | 1 | Serial bit entering stage 0 on an upward shift |
| word_in | input | WIDTH | Parallel load word |
| word_out | output | WIDTH | Registered stored word |
| end_lo | output | 1 | Stage 0 of the stored word |
| end_hi | output | 1 | Stage N-1 of the stored word |

## Verification
The bench goes after the two end stages. A design that takes the fill bit from the wrong serial input, or lets an end bit wrap around, gives a wrong MSB or LSB after a shift with all-ones or alternating patterns. It drives `shift_req` and `load_req` high together. A design that gives load the priority would copy `word_in` where a shift is expected. It also asserts reset together with a load and a shift, and it changes the control inputs of the unselected scheme. In those cases a wrong priority, or leaking control decode, shows up as a nonzero word after reset, or as a word that moves when it should stay.

// File: rtl/bidir_shreg_pkg.sv
package bidir_shreg_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_DOWN = 2'b01,
    ACT_UP   = 2'b10,
    ACT_LOAD = 2'b11
  } act_e;
endpackage

// File: rtl/bidir_shreg_decode.sv
module bidir_shreg_decode
  import bidir_shreg_pkg::*;
(
  input  logic       pair_ctrl,
  input  logic [1:0] op_code,
  input  logic       shift_req,
  input  logic       load_req,
  output act_e       act
);
  always_comb begin
    if (pair_ctrl) begin
      if (shift_req)     act = ACT_UP;
      else if (load_req) act = ACT_LOAD;
      else               act = ACT_HOLD;
    end else begin
      act = act_e'(op_code);
    end
  end
endmodule

// File: rtl/bidir_shreg_next.sv
module bidir_shreg_next
  import bidir_shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  act_e             act,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] word_in,
  input  logic             fill_dn,
  input  logic             fill_up,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] moved_dn;
  logic [WIDTH-1:0] moved_up;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == TOP) begin : g_top
      assign moved_dn[i] = fill_dn;
    end else begin : g_mid_dn
      assign moved_dn[i] = cur[i+1];
    end
    if (i == 0) begin : g_bot
      assign moved_up[i] = fill_up;
    end else begin : g_mid_up
      assign moved_up[i] = cur[i-1];
    end
  end

  always_comb begin
    unique case (act)
      ACT_DOWN: nxt = moved_dn;
      ACT_UP:   nxt = moved_up;
      ACT_LOAD: nxt = word_in;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bidir_shreg.sv
module bidir_shreg
  import bidir_shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_ctrl,
  input  logic [1:0]       op_code,
  input  logic             shift_req,
  input  logic             load_req,
  input  logic             fill_dn,
  input  logic             fill_up,
  input  logic [WIDTH-1:0] word_in,
  output logic [WIDTH-1:0] word_out,
  output logic             end_lo,
  output logic             end_hi
);
  localparam int TOP = WIDTH - 1;

  act_e             act;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  bidir_shreg_decode u_dec (
    .pair_ctrl (pair_ctrl),
    .op_code   (op_code),
    .shift_req (shift_req),
    .load_req  (load_req),
    .act       (act)
  );

  bidir_shreg_next #(.WIDTH(WIDTH)) u_nxt (
    .act     (act),
    .cur     (stage_q),
    .word_in (word_in),
    .fill_dn (fill_dn),
    .fill_up (fill_up),
    .nxt     (stage_d)
  );

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_d;
  end

  assign word_out = stage_q;
  assign end_lo   = stage_q[0];
  assign end_hi   = stage_q[TOP];
endmodule

// File: rtl/bidir_shreg_chk.sv
module bidir_shreg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             pair_ctrl,
  input logic [1:0]       op_code,
  input logic             shift_req,
  input logic             load_req,
  input logic             fill_dn,
  input logic             fill_up,
  input logic [WIDTH-1:0] word_in,
  input logic [WIDTH-1:0] word_out,
  input logic             end_lo,
  input logic             end_hi
);
  localparam int TOP = WIDTH - 1;

  // R1
  rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> word_out == '0);

  // R2
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pair_ctrl && op_code == 2'b00) |=> $stable(word_out));

  // R3
  code_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!pair_ctrl && op_code == 2'b01) |=>
      word_out == {$past(fill_dn), $past(word_out[TOP:1])});

  // R4
  code_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!pair_ctrl && op_code == 2'b10) |=>
      word_out == {$past(word_out[TOP-1:0]), $past(fill_up)});

  // R5
  code_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!pair_ctrl && op_code == 2'b11) |=> word_out == $past(word_in));

  // R6
  pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_ctrl && !shift_req && !load_req) |=> $stable(word_out));

  // R7
  pair_load_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_ctrl && !shift_req && load_req) |=> word_out == $past(word_in));

  // R8
  pair_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (pair_ctrl && shift_req) |=>
      word_out == {$past(word_out[TOP-1:0]), $past(fill_up)});

  // R9
  ends_chk: assert property (@(posedge clk) disable iff (rst)
    end_lo == word_out[0] && end_hi == word_out[TOP]);
endmodule

bind bidir_shreg bidir_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .pair_ctrl (pair_ctrl),
  .op_code   (op_code),
  .shift_req (shift_req),
  .load_req  (load_req),
  .fill_dn   (fill_dn),
  .fill_up   (fill_up),
  .word_in   (word_in),
  .word_out  (word_out),
  .end_lo    (end_lo),
  .end_hi    (end_hi)
);

// File: tb/bidir_shreg_test.sv
`timescale 1ns/1ps
module bidir_shreg_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pair_ctrl = 1'b0;
  logic [1:0]   op_code = 2'b00;
  logic         shift_req = 1'b0;
  logic         load_req = 1'b0;
  logic         fill_dn = 1'b0;
  logic         fill_up = 1'b0;
  logic [W-1:0] word_in = '0;
  logic [W-1:0] word_out;
  logic         end_lo;
  logic         end_hi;

  int           n_vec = 0;
  int           n_bad = 0;
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;

  bidir_shreg #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .pair_ctrl(pair_ctrl), .op_code(op_code),
    .shift_req(shift_req), .load_req(load_req), .fill_dn(fill_dn),
    .fill_up(fill_up), .word_in(word_in), .word_out(word_out),
    .end_lo(end_lo), .end_hi(end_hi)
  );

  function automatic logic [W-1:0] ref_next(
    input logic [W-1:0] q, input logic r, input logic pc, input logic [1:0] oc,
    input logic sr, input logic lr, input logic fd, input logic fu,
    input logic [W-1:0] wi);
    if (r) return '0;
    if (pc) begin
      if (sr) return {q[W-2:0], fu};
      if (lr) return wi;
      return q;
    end
    case (oc)
      2'b01:   return {fd, q[W-1:1]};
      2'b10:   return {q[W-2:0], fu};
      2'b11:   return wi;
      default: return q;
    endcase
  endfunction

  function automatic string req_of(input logic r, input logic pc,
                                   input logic [1:0] oc, input logic sr,
                                   input logic lr);
    if (r) return "R1";
    if (pc) return sr ? "R8" : (lr ? "R7" : "R6");
    case (oc)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare(input string req);
    n_vec++;
    if (word_out !== model) begin
      n_bad++;
      $display("FAIL %s word_out actual=%h expected=%h", req, word_out, model);
    end
    n_vec++;
    if (end_lo !== model[0] || end_hi !== model[W-1]) begin
      n_bad++;
      $display("FAIL R9 (%s) ends actual=%b%b expected=%b%b", req,
               end_hi, end_lo, model[W-1], model[0]);
    end
  endtask

  // Called just after a falling edge; checks one edge later.
  task automatic apply(input logic r, input logic pc, input logic [1:0] oc,
                       input logic sr, input logic lr, input logic fd,
                       input logic fu, input logic [W-1:0] wi,
                       input string tag);
    string req;
    rst = r; pair_ctrl = pc; op_code = oc; shift_req = sr; load_req = lr;
    fill_dn = fd; fill_up = fu; word_in = wi;
    model = ref_next(model, r, pc, oc, sr, lr, fd, fu, wi);
    req = (tag != "") ? tag : req_of(r, pc, oc, sr, lr);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    @(negedge clk);
    model = '0;
    compare("R1");
    // directed corners
    apply(0, 0, 2'b11, 0, 0, 0, 0, 8'hA5, "R5");
    apply(0, 0, 2'b01, 0, 0, 1, 0, 8'h00, "R3");   // A5 -> D2
    apply(0, 0, 2'b10, 0, 0, 0, 1, 8'h00, "R4");   // D2 -> A5
    apply(0, 0, 2'b00, 1, 1, 1, 1, 8'hFF, "R10");  // pair inputs ignored
    apply(0, 1, 2'b11, 0, 0, 1, 1, 8'h3C, "R10");  // op_code ignored
    apply(0, 1, 2'b00, 1, 1, 0, 1, 8'h00, "R8");   // shift beats load
    apply(0, 1, 2'b00, 0, 1, 0, 0, 8'h81, "R7");
    apply(0, 0, 2'b01, 0, 0, 0, 1, 8'h00, "R3");   // top fill from fill_dn only
    apply(0, 0, 2'b10, 0, 0, 1, 0, 8'h00, "R4");   // bottom fill from fill_up only
    for (int k = 0; k < W; k++) apply(0, 0, 2'b10, 0, 0, 0, 1, 8'h00, "R4");
    apply(1, 1, 2'b11, 1, 1, 1, 1, 8'hFF, "R1");   // reset beats everything
    apply(1, 0, 2'b11, 0, 0, 1, 1, 8'hFF, "R1");
    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic r;
      r = ($urandom_range(0, 31) == 0);
      apply(r, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            W'($urandom), "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule